// File: doc/BRIEF.md
# Stack-Pop Return Sequencer

This block carries out the return instructions of a 16-bit real-mode processor. It runs over several cycles. A start strobe comes with an opcode, an optional 16-bit immediate and the current stack pointer and stack segment. The block then pops one, two or three words from the stack through a simple read port. Each word is routed to the instruction pointer, the code segment or the flags. The block writes back the new stack pointer and ends with a one-cycle done strobe.

There are five kinds of return, and one controller handles all of them:

| Opcode | Return kind | Words popped | Extra SP release |
|---|---|---|---|
| 0xC3 | near | 1 (IP) | none |
| 0xC2 | near | 1 (IP) | immediate |
| 0xCB | far | 2 (IP, CS) | none |
| 0xCA | far | 2 (IP, CS) | immediate |
| 0xCF | interrupt | 3 (IP, CS, FLAGS) | none |

The immediate is added to SP after the pops. The interrupt return also reloads the flags and raises a one-cycle interrupt-inhibit pulse. Fetch, decode, the register file and the physical address computation stay outside the block.

Top module: `ret_seq`

## Requirements
- R1: After reset, mem_req_o, done_o, int_inhibit_o and every write strobe (ip_we_o, cs_we_o, flags_we_o, sp_we_o) are low.
- R2: Opcode 0xC3 pops one word into IP, and the final SP is the start SP plus 2.
- R3: Opcode 0xC2 pops one word into IP, and the final SP is the start SP plus 2 plus imm_i.
- R4: Opcode 0xCB pops IP first and CS second, and the final SP is the start SP plus 4.
- R5: Opcode 0xCA pops IP then CS, and the final SP is the start SP plus 4 plus imm_i.
- R6: Opcode 0xCF pops IP, then CS, then the flags word, in that order, and the final SP is the start SP plus 6.
- R7: Every stack read puts the start SS on mem_seg_o. The first read offset is the start SP, and each later read is 2 above the one before.
- R8: The flags value written is the popped word with only these bits kept: CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10, OF=11. The reserved bits 1, 3, 5 and 12–15 read as zero (mask 0x0FD5).
- R9: int_inhibit_o pulses high together with done_o for opcode 0xCF only, and is low at all other times.
- R10: A read request stays high with a stable offset until mem_valid_i is seen high. The word on mem_rdata_i in that cycle is the one consumed.
- R11: sp_we_o pulses once per return. done_o pulses for exactly one cycle, in the cycle right after sp_we_o.
- R12: Any other opcode raises done_o in the cycle after the start. It issues no read and no write strobe, and the held IP, CS, FLAGS and SP outputs do not change.
- R13: All offset and SP arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a return; sampled only while idle |
| opcode_i | input | 8 | Return opcode |
| imm_i | input | 16 | Stack-release immediate |
| sp_i | input | 16 | Current stack pointer |
| ss_i | input | 16 | Current stack segment |
| mem_req_o | output | 1 | Stack read request |
| mem_seg_o | output | 16 | Read segment |
| mem_off_o | output | 16 | Read offset |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |
| ip_we_o | output | 1 | IP load strobe |
| ip_o | output | 16 | IP value |
| cs_we_o | output | 1 | CS load strobe |
| cs_o | output | 16 | CS value |
| flags_we_o | output | 1 | Flags load strobe |
| flags_o | output | 16 | Flags value |
| sp_we_o | output | 1 | SP load strobe |
| sp_o | output | 16 | Updated SP |
| int_inhibit_o | output | 1 | External-interrupt inhibit pulse |
| done_o | output | 1 | Completion pulse |

## Verification
Each opcode runs once with read data returned at once and once with extra wait cycles.

- Zero-latency runs show that pops, strobes and the SP write fall in the right cycles.
- Delayed runs show that a request is held and that the data is not taken early.
- An all-ones flags word separates the kept flag bits from the reserved ones.
- Stack pointers near 0xFFFF show wrap-around in both the read offsets and the final SP.
- An unrecognised opcode shows the completion path that touches no state.

// File: rtl/ret_pkg.sv
package ret_pkg;
  localparam int unsigned WORD_W = 16;

  localparam logic [7:0] OP_NEAR     = 8'hC3;
  localparam logic [7:0] OP_NEAR_IMM = 8'hC2;
  localparam logic [7:0] OP_FAR      = 8'hCB;
  localparam logic [7:0] OP_FAR_IMM  = 8'hCA;
  localparam logic [7:0] OP_INT      = 8'hCF;

  // kept flag bits: 0,2,4,6,7,8,9,10,11
  localparam logic [15:0] FLAG_KEEP = 16'h0FD5;

  typedef enum logic [1:0] {ST_IDLE, ST_POP, ST_SP, ST_END} st_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] pops;
    logic       imm;
    logic       iret;
  } dec_t;
endpackage

// File: rtl/ret_decode.sv
module ret_decode
  import ret_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (opcode_i)
      OP_NEAR:     dec_o = '{ok: 1'b1, pops: 2'd1, imm: 1'b0, iret: 1'b0};
      OP_NEAR_IMM: dec_o = '{ok: 1'b1, pops: 2'd1, imm: 1'b1, iret: 1'b0};
      OP_FAR:      dec_o = '{ok: 1'b1, pops: 2'd2, imm: 1'b0, iret: 1'b0};
      OP_FAR_IMM:  dec_o = '{ok: 1'b1, pops: 2'd2, imm: 1'b1, iret: 1'b0};
      OP_INT:      dec_o = '{ok: 1'b1, pops: 2'd3, imm: 1'b0, iret: 1'b1};
      default:     dec_o = '0;
    endcase
  end
endmodule

// File: rtl/ret_flag_merge.sv
module ret_flag_merge #(
  parameter int unsigned DW = ret_pkg::WORD_W
) (
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] flags_o
);
  localparam logic [DW-1:0] KEEP = DW'(ret_pkg::FLAG_KEEP);

  assign flags_o = word_i & KEEP;
endmodule

// File: rtl/ret_fsm.sv
module ret_fsm
  import ret_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  dec_t          dec_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ss_i,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] flag_word_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_seg_o,
  output logic [DW-1:0] mem_off_o,
  output logic          ip_we_o,
  output logic [DW-1:0] ip_o,
  output logic          cs_we_o,
  output logic [DW-1:0] cs_o,
  output logic          flags_we_o,
  output logic [DW-1:0] flags_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_o,
  output logic          int_inhibit_o,
  output logic          done_o
);
  localparam logic [DW-1:0] STEP = DW'(2);

  st_e           st_q;
  logic [1:0]    cnt_q, pops_q;
  logic          iret_q;
  logic [DW-1:0] off_q, seg_q, imm_q;

  assign mem_req_o = (st_q == ST_POP);
  assign mem_seg_o = seg_q;
  assign mem_off_o = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      pops_q        <= '0;
      iret_q        <= 1'b0;
      off_q         <= '0;
      seg_q         <= '0;
      imm_q         <= '0;
      ip_we_o       <= 1'b0;
      cs_we_o       <= 1'b0;
      flags_we_o    <= 1'b0;
      sp_we_o       <= 1'b0;
      ip_o          <= '0;
      cs_o          <= '0;
      flags_o       <= '0;
      sp_o          <= '0;
      int_inhibit_o <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      ip_we_o       <= 1'b0;
      cs_we_o       <= 1'b0;
      flags_we_o    <= 1'b0;
      sp_we_o       <= 1'b0;
      int_inhibit_o <= 1'b0;
      done_o        <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (dec_i.ok) begin
              pops_q <= dec_i.pops;
              iret_q <= dec_i.iret;
              off_q  <= sp_i;
              seg_q  <= ss_i;
              imm_q  <= dec_i.imm ? imm_i : '0;
              cnt_q  <= '0;
              st_q   <= ST_POP;
            end else begin
              done_o <= 1'b1;  // unknown opcode: finish, touch nothing
            end
          end
        end
        ST_POP: begin
          if (mem_valid_i) begin
            unique case (cnt_q)
              2'd0: begin ip_o <= mem_rdata_i; ip_we_o <= 1'b1; end
              2'd1: begin cs_o <= mem_rdata_i; cs_we_o <= 1'b1; end
              default: begin flags_o <= flag_word_i; flags_we_o <= 1'b1; end
            endcase
            off_q <= off_q + STEP;
            if (cnt_q == pops_q - 2'd1) st_q <= ST_SP;
            else cnt_q <= cnt_q + 2'd1;
          end
        end
        ST_SP: begin
          sp_o    <= off_q + imm_q;
          sp_we_o <= 1'b1;
          st_q    <= ST_END;
        end
        default: begin
          done_o        <= 1'b1;
          int_inhibit_o <= iret_q;
          st_q          <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ret_seq.sv
module ret_seq
  import ret_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ss_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_seg_o,
  output logic [DW-1:0] mem_off_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          ip_we_o,
  output logic [DW-1:0] ip_o,
  output logic          cs_we_o,
  output logic [DW-1:0] cs_o,
  output logic          flags_we_o,
  output logic [DW-1:0] flags_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_o,
  output logic          int_inhibit_o,
  output logic          done_o
);
  dec_t          dec;
  logic [DW-1:0] flag_word;

  ret_decode u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  ret_flag_merge #(.DW(DW)) u_flag (
    .word_i  (mem_rdata_i),
    .flags_o (flag_word)
  );

  ret_fsm #(.DW(DW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .dec_i         (dec),
    .imm_i         (imm_i),
    .sp_i          (sp_i),
    .ss_i          (ss_i),
    .mem_valid_i   (mem_valid_i),
    .mem_rdata_i   (mem_rdata_i),
    .flag_word_i   (flag_word),
    .mem_req_o     (mem_req_o),
    .mem_seg_o     (mem_seg_o),
    .mem_off_o     (mem_off_o),
    .ip_we_o       (ip_we_o),
    .ip_o          (ip_o),
    .cs_we_o       (cs_we_o),
    .cs_o          (cs_o),
    .flags_we_o    (flags_we_o),
    .flags_o       (flags_o),
    .sp_we_o       (sp_we_o),
    .sp_o          (sp_o),
    .int_inhibit_o (int_inhibit_o),
    .done_o        (done_o)
  );
endmodule

// File: rtl/ret_seq_chk.sv
module ret_seq_chk #(
  parameter int unsigned DW = ret_pkg::WORD_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_valid_i,
  input logic [DW-1:0] mem_off_o,
  input logic          ip_we_o,
  input logic          cs_we_o,
  input logic          flags_we_o,
  input logic          sp_we_o,
  input logic          int_inhibit_o,
  input logic          done_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_off_o))); // R10

  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (!mem_req_o || mem_off_o == $past(mem_off_o) + DW'(2))); // R7

  AST_DONE_AFTER_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> done_o); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_INHIBIT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_inhibit_o |-> done_o); // R9

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ip_we_o, cs_we_o, flags_we_o, sp_we_o})); // R6

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R12
endmodule

bind ret_seq ret_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_ret_seq.sv
module sim_ret_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] imm_i = '0, sp_i = '0, ss_i = '0;
  logic        mem_valid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_req_o, ip_we_o, cs_we_o, flags_we_o, sp_we_o, int_inhibit_o, done_o;
  logic [15:0] mem_seg_o, mem_off_o, ip_o, cs_o, flags_o, sp_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  ret_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_ret(input logic [7:0] op, input logic [15:0] imm,
                         input logic [15:0] sp, input logic [15:0] ss,
                         input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input int lat, input string req);
    logic [15:0] w[3];
    logic [15:0] exp_sp, got_ip, got_cs, got_fl, got_sp;
    int pops, k, wait_cnt, ip_at, cs_at, fl_at, sp_at, done_at, n_sp;
    bit fin, inh, inh_other, has_imm;
    w[0] = w0; w[1] = w1; w[2] = w2;
    pops = (op == 8'hC3 || op == 8'hC2) ? 1 : (op == 8'hCB || op == 8'hCA) ? 2 : 3;
    has_imm = (op == 8'hC2 || op == 8'hCA);
    exp_sp = sp + 16'(2 * pops) + (has_imm ? imm : 16'h0);
    k = 0; wait_cnt = 0; fin = 0; inh = 0; inh_other = 0; n_sp = 0;
    ip_at = -1; cs_at = -1; fl_at = -1; sp_at = -1; done_at = -1;
    got_ip = '0; got_cs = '0; got_fl = '0; got_sp = '0;
    @(negedge clk_i);
    opcode_i = op; imm_i = imm; sp_i = sp; ss_i = ss; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 100 && !fin; c++) begin
      mem_valid_i = 1'b0;
      if (ip_we_o) begin got_ip = ip_o; ip_at = c; end
      if (cs_we_o) begin got_cs = cs_o; cs_at = c; end
      if (flags_we_o) begin got_fl = flags_o; fl_at = c; end
      if (sp_we_o) begin got_sp = sp_o; sp_at = c; n_sp++; end
      if (int_inhibit_o && !done_o) inh_other = 1;
      if (done_o) begin done_at = c; inh = int_inhibit_o; fin = 1; end
      if (mem_req_o && !fin) begin
        chk(mem_seg_o == ss, "R7", "read segment", mem_seg_o, ss);
        chk(mem_off_o == sp + 16'(2 * k), "R7", "read offset", mem_off_o, sp + 16'(2 * k));
        if (wait_cnt == lat) begin
          mem_rdata_i = (k < 3) ? w[k] : 16'hDEAD;
          mem_valid_i = 1'b1;
          k++;
          wait_cnt = 0;
        end else begin
          mem_rdata_i = 16'hBAD0;  // must not be consumed without valid (R10)
          wait_cnt++;
        end
      end
      @(negedge clk_i);
    end
    mem_valid_i = 1'b0;
    chk(fin, req, "done seen", fin, 1);
    chk(k == pops, "R7", "number of reads", k, pops);
    chk(got_ip == w0 && ip_at >= 0, req, "IP popped", got_ip, w0);
    if (pops >= 2) begin
      chk(got_cs == w1 && cs_at > ip_at, req, "CS popped after IP", got_cs, w1);
    end else begin
      chk(cs_at < 0, req, "no CS write", cs_at, -1);
    end
    if (pops == 3) begin
      chk(fl_at > cs_at, "R6", "FLAGS popped after CS", fl_at, cs_at + 1);
      chk(got_fl == (w2 & 16'h0FD5), "R8", "flags mask", got_fl, w2 & 16'h0FD5);
    end else begin
      chk(fl_at < 0, req, "no FLAGS write", fl_at, -1);
    end
    chk(got_sp == exp_sp, req, "final SP", got_sp, exp_sp);
    chk(n_sp == 1 && done_at == sp_at + 1, "R11", "done after SP write", done_at, sp_at + 1);
    chk(inh == (op == 8'hCF) && !inh_other, "R9", "inhibit pulse", inh, op == 8'hCF);
    @(negedge clk_i);
    chk(!done_o && !int_inhibit_o, "R11", "done single cycle", done_o, 0);
  endtask

  task automatic t_reset;
    chk(!mem_req_o && !done_o && !int_inhibit_o, "R1", "req/done/inhibit idle", {mem_req_o, done_o, int_inhibit_o}, 0);
    chk(!ip_we_o && !cs_we_o && !flags_we_o && !sp_we_o, "R1", "strobes idle",
        {ip_we_o, cs_we_o, flags_we_o, sp_we_o}, 0);
  endtask

  task automatic t_near;
    run_ret(8'hC3, 16'h7777, 16'h1000, 16'h3000, 16'h1234, 16'h0, 16'h0, 0, "R2");
    run_ret(8'hC3, 16'h0000, 16'h2002, 16'h3100, 16'hABCD, 16'h0, 16'h0, 3, "R2");
  endtask

  task automatic t_near_imm;
    run_ret(8'hC2, 16'h0006, 16'h0400, 16'h5000, 16'h4321, 16'h0, 16'h0, 0, "R3");
    run_ret(8'hC2, 16'h0010, 16'hFFFE, 16'h5000, 16'h0042, 16'h0, 16'h0, 2, "R13");
  endtask

  task automatic t_far;
    run_ret(8'hCB, 16'h5555, 16'h0800, 16'h6000, 16'h1111, 16'h2222, 16'h0, 0, "R4");
    run_ret(8'hCB, 16'h0000, 16'h0900, 16'h6100, 16'h3333, 16'h4444, 16'h0, 4, "R4");
  endtask

  task automatic t_far_imm;
    run_ret(8'hCA, 16'h0008, 16'h0A00, 16'h7000, 16'h5555, 16'h6666, 16'h0, 1, "R5");
    run_ret(8'hCA, 16'h0010, 16'hFFFC, 16'h7000, 16'h7777, 16'h8888, 16'h0, 0, "R13");
  endtask

  task automatic t_iret;
    run_ret(8'hCF, 16'h0040, 16'h0C00, 16'h8000, 16'h9999, 16'hAAAA, 16'hFFFF, 0, "R6");
    run_ret(8'hCF, 16'h0000, 16'hFFFE, 16'h8100, 16'h0102, 16'h0304, 16'hF02A, 2, "R13");
  endtask

  task automatic t_unknown;
    logic [15:0] ip0, cs0, fl0, sp0;
    bit bad;
    ip0 = ip_o; cs0 = cs_o; fl0 = flags_o; sp0 = sp_o;
    bad = 0;
    @(negedge clk_i);
    opcode_i = 8'h90; sp_i = 16'h1234; imm_i = 16'h0002; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o, "R12", "done next cycle", done_o, 1);
    for (int c = 0; c < 4; c++) begin
      if (mem_req_o || ip_we_o || cs_we_o || flags_we_o || sp_we_o || int_inhibit_o) bad = 1;
      @(negedge clk_i);
    end
    chk(!bad, "R12", "no read or strobe", bad, 0);
    chk(ip_o == ip0 && cs_o == cs0 && flags_o == fl0 && sp_o == sp0, "R12", "state unchanged", sp_o, sp0);
    chk(!done_o, "R12", "done single cycle", done_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_near();
    t_near_imm();
    t_far();
    t_far_imm();
    t_iret();
    t_unknown();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule